// File: doc/BRIEF.md
# Opcode-Selected Unsigned Arithmetic and Logic Unit

This block is a purely combinational datapath element that takes two 8-bit unsigned operands and a 5-bit function code and produces one 16-bit result word. It covers seventeen functions: widening add, subtract, multiply, increment and decrement; single-position logical shifts; equality and unsigned magnitude comparisons; and seven bitwise logic functions. No register, clock or flag output is present. The result appears as soon as the inputs settle.

The 16-bit result is twice the operand width. Sums, increments and products therefore always fit, and no carry signal is needed. Subtraction and decrement wrap in 16-bit two's complement. Comparisons return the integer 0 or 1 in the result word rather than setting a flag. Every shift and logic result is an 8-bit value placed in the low byte with the high byte cleared. The function codes that are not assigned return zero.

Top module: `opsel_alu`

## Requirements
- R1: Code 00000 returns the unsigned sum A+B as a full 16-bit value (255+255 gives 16'h01FE).
- R2: Code 00001 returns A−B modulo 2^16, so A<B wraps (0−1 gives 16'hFFFF, 3−5 gives 16'hFFFE).
- R3: Code 00010 returns the full unsigned product A×B (255×255 gives 16'hFE01).
- R4: Code 00011 returns A+1 without truncation (255 gives 16'h0100). Code 00100 returns A−1 modulo 2^16 (0 gives 16'hFFFF). B is ignored for both codes.
- R5: Code 00101 shifts A left by one bit inside 8 bits. Bit 7 is discarded, a zero enters bit 0, and bits [15:8] are zero (8'h81 gives 16'h0002).
- R6: Code 00110 shifts A right by one bit logically. A zero enters bit 7, and bits [15:8] are zero (8'h81 gives 16'h0040).
- R7: Codes 00111, 01000 and 01001 return 16'h0001 when A==B, A<B or A>B holds respectively, and 16'h0000 otherwise, with an unsigned comparison.
- R8: Codes 01010 through 01111 return, in that order, bitwise AND, OR, XOR, NAND, NOR and XNOR of A and B in bits [7:0], with bits [15:8] zero.
- R9: Code 10000 returns bitwise NOT of A in bits [7:0] with bits [15:8] zero, and B has no effect on the result.
- R10: Codes 10001 through 11111 return 16'h0000 for any operands.
- R11: The result depends only on the present inputs. A new input value is reflected on the result without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand, unsigned |
| b_i | input | 8 | Second operand, unsigned |
| sel_i | input | 5 | Function code |
| res_o | output | 16 | Result word |

## Verification
Every function code is driven with operand extremes (0, 1, 255) and with values near each other. The extremes separate truncated arithmetic from full-width arithmetic, and they expose a missing wrap in subtraction and decrement. The shift tests use 8'h81, whose two outer bits show whether a bit leaks into bit 8 or back in at the vacated end. The comparison tests use equal pairs, adjacent pairs and pairs with the top bit set, which separate strict from non-strict tests and unsigned from signed ones. A sweep of all 32 codes over a spread of operand pairs compares each result against an independent integer model. Repeating the NOT code with changed B confirms that B has no effect.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  localparam int OPND_W = 8;
  localparam int SEL_W  = 5;

  typedef enum logic [SEL_W-1:0] {
    FN_ADD   = 5'd0,
    FN_SUB   = 5'd1,
    FN_MUL   = 5'd2,
    FN_INC   = 5'd3,
    FN_DEC   = 5'd4,
    FN_SHL   = 5'd5,
    FN_SHR   = 5'd6,
    FN_EQ    = 5'd7,
    FN_LT    = 5'd8,
    FN_GT    = 5'd9,
    FN_AND   = 5'd10,
    FN_OR    = 5'd11,
    FN_XOR   = 5'd12,
    FN_NAND  = 5'd13,
    FN_NOR   = 5'd14,
    FN_XNOR  = 5'd15,
    FN_NOTA  = 5'd16
  } alu_fn_e;

  localparam logic [SEL_W-1:0] FN_LAST = 5'd16;

endpackage

// File: rtl/opsel_arith.sv
module opsel_arith
  import opsel_alu_pkg::*;
#(
  parameter int OPND_W = opsel_alu_pkg::OPND_W,
  localparam int RES_W = 2 * OPND_W
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [RES_W-1:0]  res_o
);

  function automatic logic [RES_W-1:0] widen(input logic [OPND_W-1:0] v);
    return {{OPND_W{1'b0}}, v};
  endfunction

  function automatic logic [RES_W-1:0] wide_add(input logic [OPND_W-1:0] x,
                                                input logic [OPND_W-1:0] y);
    return widen(x) + widen(y);
  endfunction

  function automatic logic [RES_W-1:0] wide_sub(input logic [OPND_W-1:0] x,
                                                input logic [OPND_W-1:0] y);
    return widen(x) - widen(y);
  endfunction

  function automatic logic [RES_W-1:0] wide_mul(input logic [OPND_W-1:0] x,
                                                input logic [OPND_W-1:0] y);
    return widen(x) * widen(y);
  endfunction

  localparam logic [OPND_W-1:0] ONE = OPND_W'(1);

  logic [RES_W-1:0] sum_w, diff_w, prod_w, inc_w, dec_w;

  assign sum_w  = wide_add(a_i, b_i);
  assign diff_w = wide_sub(a_i, b_i);
  assign prod_w = wide_mul(a_i, b_i);
  assign inc_w  = wide_add(a_i, ONE);
  assign dec_w  = wide_sub(a_i, ONE);

  always_comb begin
    unique case (fn_i)
      FN_ADD:  res_o = sum_w;
      FN_SUB:  res_o = diff_w;
      FN_MUL:  res_o = prod_w;
      FN_INC:  res_o = inc_w;
      FN_DEC:  res_o = dec_w;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    // R1
    if (fn_i == FN_ADD)
      sum_roundtrip_chk: assert (res_o - widen(b_i) == widen(a_i))
        else $error("sum does not subtract back to A");
    // R2
    if (fn_i == FN_SUB)
      diff_roundtrip_chk: assert (res_o + widen(b_i) == widen(a_i))
        else $error("difference does not add back to A");
    // R4
    if (fn_i == FN_INC)
      inc_above_chk: assert (res_o > widen(a_i))
        else $error("increment not above A");
  end

endmodule

// File: rtl/opsel_bitops.sv
module opsel_bitops
  import opsel_alu_pkg::*;
#(
  parameter int OPND_W = opsel_alu_pkg::OPND_W
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [OPND_W-1:0] byte_o
);

  logic [OPND_W-1:0] and_w, or_w, xor_w, shl_w, shr_w;

  assign and_w = a_i & b_i;
  assign or_w  = a_i | b_i;
  assign xor_w = a_i ^ b_i;
  assign shl_w = {a_i[OPND_W-2:0], 1'b0};
  assign shr_w = {1'b0, a_i[OPND_W-1:1]};

  always_comb begin
    unique case (fn_i)
      FN_SHL:  byte_o = shl_w;
      FN_SHR:  byte_o = shr_w;
      FN_AND:  byte_o = and_w;
      FN_OR:   byte_o = or_w;
      FN_XOR:  byte_o = xor_w;
      FN_NAND: byte_o = ~and_w;
      FN_NOR:  byte_o = ~or_w;
      FN_XNOR: byte_o = ~xor_w;
      FN_NOTA: byte_o = ~a_i;
      default: byte_o = '0;
    endcase
  end

  always_comb begin
    // R5
    if (fn_i == FN_SHL)
      shl_lsb_chk: assert (byte_o[0] == 1'b0)
        else $error("left shift filled bit 0");
    // R6
    if (fn_i == FN_SHR)
      shr_msb_chk: assert (byte_o[OPND_W-1] == 1'b0)
        else $error("right shift filled top bit");
  end

endmodule

// File: rtl/opsel_compare.sv
module opsel_compare
  import opsel_alu_pkg::*;
#(
  parameter int OPND_W = opsel_alu_pkg::OPND_W
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic              hit_o
);

  logic eq_w, lt_w, gt_w;

  assign eq_w = (a_i == b_i);
  assign lt_w = (a_i <  b_i);
  assign gt_w = (b_i <  a_i);

  always_comb begin
    unique case (fn_i)
      FN_EQ:   hit_o = eq_w;
      FN_LT:   hit_o = lt_w;
      FN_GT:   hit_o = gt_w;
      default: hit_o = 1'b0;
    endcase
  end

  always_comb begin
    // R7
    cmp_exclusive_chk: assert ($countones({eq_w, lt_w, gt_w}) == 1)
      else $error("comparison outcomes not exclusive");
  end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int OPND_W = opsel_alu_pkg::OPND_W,
  parameter int SEL_W  = opsel_alu_pkg::SEL_W,
  localparam int RES_W = 2 * OPND_W
) (
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [RES_W-1:0]  res_o
);

  typedef enum logic [1:0] {GRP_NONE, GRP_ARITH, GRP_BYTE, GRP_CMP} grp_e;

  alu_fn_e           fn_w;
  grp_e              grp_w;
  logic [RES_W-1:0]  arith_w;
  logic [OPND_W-1:0] byte_w;
  logic              hit_w;
  logic              known_w;

  assign known_w = (sel_i <= FN_LAST);
  assign fn_w    = known_w ? alu_fn_e'(sel_i) : FN_ADD;

  always_comb begin
    if (!known_w) grp_w = GRP_NONE;
    else begin
      unique case (fn_w)
        FN_ADD, FN_SUB, FN_MUL, FN_INC, FN_DEC: grp_w = GRP_ARITH;
        FN_EQ, FN_LT, FN_GT:                    grp_w = GRP_CMP;
        default:                                grp_w = GRP_BYTE;
      endcase
    end
  end

  opsel_arith #(.OPND_W(OPND_W)) arith_i (
    .a_i(a_i), .b_i(b_i), .fn_i(fn_w), .res_o(arith_w)
  );

  opsel_bitops #(.OPND_W(OPND_W)) bitops_i (
    .a_i(a_i), .b_i(b_i), .fn_i(fn_w), .byte_o(byte_w)
  );

  opsel_compare #(.OPND_W(OPND_W)) cmp_i (
    .a_i(a_i), .b_i(b_i), .fn_i(fn_w), .hit_o(hit_w)
  );

  always_comb begin
    unique case (grp_w)
      GRP_ARITH: res_o = arith_w;
      GRP_BYTE:  res_o = {{OPND_W{1'b0}}, byte_w};
      GRP_CMP:   res_o = {{(RES_W-1){1'b0}}, hit_w};
      default:   res_o = '0;
    endcase
  end

  always_comb begin
    // R10
    if (!known_w)
      unassigned_zero_chk: assert (res_o == '0)
        else $error("unassigned code gave nonzero result");
    // R8
    if (grp_w == GRP_BYTE)
      byte_upper_zero_chk: assert (res_o[RES_W-1:OPND_W] == '0)
        else $error("byte result leaked into upper half");
    // R9
    if (known_w && fn_w == FN_NOTA)
      nota_complement_chk: assert ((res_o[OPND_W-1:0] ^ a_i) == {OPND_W{1'b1}})
        else $error("NOT result is not complement of A");
    // R3
    if (known_w && fn_w == FN_MUL && b_i == OPND_W'(1))
      mul_identity_chk: assert (res_o == {{OPND_W{1'b0}}, a_i})
        else $error("product by one differs from A");
  end

endmodule

// File: tb/opsel_alu_tb.sv
`timescale 1ns/1ps
module opsel_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a, b;
  logic [4:0] sel;
  logic [15:0] res;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opsel_alu dut_i (.a_i(a), .b_i(b), .sel_i(sel), .res_o(res));

  initial begin a = 8'd0; b = 8'd0; sel = 5'd0; end

  function automatic logic [15:0] model(int s, int x, int y);
    int r;
    case (s)
      0: r = x + y;
      1: r = (x - y + 65536) % 65536;
      2: r = x * y;
      3: r = x + 1;
      4: r = (x + 65535) % 65536;
      5: r = (x * 2) % 256;
      6: r = x / 2;
      7: r = (x == y) ? 1 : 0;
      8: r = (x < y) ? 1 : 0;
      9: r = (x > y) ? 1 : 0;
      10: r = x & y;
      11: r = x | y;
      12: r = x ^ y;
      13: r = 255 - (x & y);
      14: r = 255 - (x | y);
      15: r = 255 - (x ^ y);
      16: r = 255 - x;
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  task automatic apply_check(int s, int x, int y, logic [15:0] exp, string req);
    @(negedge clk);
    sel = s[4:0]; a = x[7:0]; b = y[7:0];
    #1;
    n_cmp++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%0d a=%0d b=%0d actual=%h expected=%h", req, s, x, y, res, exp);
    end
  endtask

  task automatic t_reset_state();
    apply_check(0, 0, 0, 16'h0000, "R1 idle");
  endtask

  task automatic t_arith();
    apply_check(0, 255, 255, 16'h01FE, "R1");
    apply_check(0, 17, 40, 16'd57, "R1");
    apply_check(1, 0, 1, 16'hFFFF, "R2");
    apply_check(1, 3, 5, 16'hFFFE, "R2");
    apply_check(1, 200, 55, 16'd145, "R2");
    apply_check(2, 255, 255, 16'hFE01, "R3");
    apply_check(2, 16, 16, 16'h0100, "R3");
    apply_check(3, 255, 9, 16'h0100, "R4");
    apply_check(4, 0, 77, 16'hFFFF, "R4");
    apply_check(4, 128, 3, 16'h007F, "R4");
  endtask

  task automatic t_shift();
    apply_check(5, 8'h81, 0, 16'h0002, "R5");
    apply_check(5, 8'h7F, 255, 16'h00FE, "R5");
    apply_check(6, 8'h81, 0, 16'h0040, "R6");
    apply_check(6, 8'h01, 255, 16'h0000, "R6");
  endtask

  task automatic t_compare();
    apply_check(7, 42, 42, 16'h0001, "R7");
    apply_check(7, 42, 43, 16'h0000, "R7");
    apply_check(8, 42, 43, 16'h0001, "R7");
    apply_check(8, 43, 43, 16'h0000, "R7");
    apply_check(8, 8'h80, 8'h01, 16'h0000, "R7");
    apply_check(9, 8'h80, 8'h01, 16'h0001, "R7");
    apply_check(9, 5, 5, 16'h0000, "R7");
  endtask

  task automatic t_logic();
    apply_check(10, 8'hF0, 8'h3C, 16'h0030, "R8");
    apply_check(11, 8'hF0, 8'h3C, 16'h00FC, "R8");
    apply_check(12, 8'hF0, 8'h3C, 16'h00CC, "R8");
    apply_check(13, 8'hF0, 8'h3C, 16'h00CF, "R8");
    apply_check(14, 8'hF0, 8'h3C, 16'h0003, "R8");
    apply_check(15, 8'hF0, 8'h3C, 16'h0033, "R8");
  endtask

  task automatic t_not();
    apply_check(16, 8'hA5, 8'h00, 16'h005A, "R9");
    apply_check(16, 8'hA5, 8'hFF, 16'h005A, "R9");
    apply_check(16, 8'h00, 8'h3C, 16'h00FF, "R9");
  endtask

  task automatic t_unassigned();
    for (int s = 17; s < 32; s++) apply_check(s, 255, 255, 16'h0000, "R10");
  endtask

  task automatic t_sweep();
    int vals[6] = '{0, 1, 127, 128, 200, 255};
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 6; i++)
        apply_check(s, vals[i], vals[5 - i], model(s, vals[i], vals[5 - i]), "R11 sweep");
  endtask

  task automatic t_no_clock();
    @(negedge clk);
    sel = 5'd0; a = 8'd1; b = 8'd2;
    #0.5;
    a = 8'd10;
    #0.5;
    n_cmp++;
    if (res !== 16'd12) begin
      n_bad++;
      $display("FAIL R11 actual=%h expected=%h", res, 16'd12);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_arith();
    t_shift();
    t_compare();
    t_logic();
    t_not();
    t_unassigned();
    t_sweep();
    t_no_clock();
    finish_run();
  end

  initial begin
    #500000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule